// File: doc/BRIEF.md
# Exception Cause and Return-Address Capture

This block keeps the state a processor records at the moment it takes an exception. It has three registers. The cause word holds the exception code, the branch-delay flag, the coprocessor unit number and eight interrupt-pending bits. The return-address register holds the resume PC for ordinary exceptions. A separate error return-address register holds the resume PC for reset and non-maskable-interrupt entries. The pipeline raises a one-cycle strobe with the code, the faulting PC, a delay-slot flag and a coprocessor number, and the block latches them.

When the faulting instruction sits in a branch delay slot, the block moves the captured address back one instruction so that it points at the branch, and it sets the delay flag. Reset and NMI entries use their own strobe. They never carry a delay indication. The hardware pending bits follow the timer line and the external request lines on every cycle. Software may write the two software-interrupt bits and both return-address registers through a simple write port.

Top module: `exc_capture_top`

## Requirements
- R1: After reset, the cause word, the return address and the error return address all read zero.
- R2: When `exc_take` is high and `exc_in_delay` is low, the next cycle shows `epc_q` equal to `exc_pc`, and the delay flag (cause bit 31) is clear.
- R3: When `exc_take` is high and `exc_in_delay` is high, the next cycle shows `epc_q` equal to `exc_pc` minus 4, modulo 2^XLEN, and cause bit 31 is set.
- R4: On `exc_take`, cause bits [6:2] take `exc_code`.
- R5: On `exc_take`, cause bits [29:28] take `exc_cop_num`.
- R6: Every cycle, cause bits [15:10] take `{timer_irq, ext_irq[4:0]}` with one register of latency. Cause bit 15 is the timer bit and bits 14 to 10 are the external lines 4 to 0.
- R7: A write with `wr_sel`=0 (cause) loads cause bits [9:8] from `wr_data[1:0]`. Every other cause field ignores the write, and cause bits 30, 27:16, 7 and 1:0 always read zero.
- R8: On `err_take`, `errorepc_q` takes `err_pc` unchanged, whatever `exc_in_delay` is. The cause word and `epc_q` are not altered by it.
- R9: A write with `wr_sel`=1 loads `epc_q`, and `wr_sel`=2 loads `errorepc_q`, from `wr_data`. `wr_sel`=3 changes no register.
- R10: In the same cycle, an exception capture wins over a software write to the same return-address register. A cause write with a simultaneous `exc_take` still updates cause bits [9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_take | input | 1 | Ordinary exception taken this cycle |
| exc_code | input | 5 | Exception code |
| exc_pc | input | XLEN | Virtual address of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| exc_cop_num | input | 2 | Coprocessor unit referenced |
| err_take | input | 1 | Reset or NMI entry taken this cycle |
| err_pc | input | XLEN | Resume PC for reset/NMI |
| ext_irq | input | 5 | External interrupt request lines |
| timer_irq | input | 1 | Timer compare match pending |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 2 | Write target: 0 cause, 1 return address, 2 error return address, 3 none |
| wr_data | input | XLEN | Software write data |
| cause_q | output | 32 | Cause word |
| epc_q | output | XLEN | Exception return address |
| errorepc_q | output | XLEN | Error return address |

## Verification
Two functions can land in the same cycle: a hardware capture and a software write. The first case is an exception strobe issued in the same cycle as a write to the return-address register. The second is a reset/NMI strobe issued with a write to the error return-address register. The third is an exception issued with a cause write that sets the software bits. In each case the bench expects the hardware value in the return-address registers. It also expects the captured code, delay flag and coprocessor number to sit in the cause word alongside the newly written software bits. The delay-slot adjustment is also exercised at address zero to confirm that it wraps.

// File: rtl/exc_capture_pkg.sv
package exc_capture_pkg;
  localparam int CAUSE_W  = 32;
  localparam int CODE_W   = 5;
  localparam int COP_W    = 2;
  localparam int EXT_W    = 5;
  localparam int HWIP_W   = EXT_W + 1;
  localparam int SWIP_W   = 2;

  localparam int BD_POS   = 31;
  localparam int COP_LSB  = 28;
  localparam int HWIP_LSB = 10;
  localparam int SWIP_LSB = 8;
  localparam int CODE_LSB = 2;

  typedef enum logic [1:0] {
    SEL_CAUSE   = 2'd0,
    SEL_EPC     = 2'd1,
    SEL_ERR_EPC = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic              bd;
    logic [COP_W-1:0]  cop;
    logic [HWIP_W-1:0] hw_ip;
    logic [SWIP_W-1:0] sw_ip;
    logic [CODE_W-1:0] code;
  } cause_t;

  function automatic logic [CAUSE_W-1:0] pack_cause(input cause_t c);
    logic [CAUSE_W-1:0] w;
    w = '0;
    w[BD_POS]                     = c.bd;
    w[COP_LSB +: COP_W]           = c.cop;
    w[HWIP_LSB +: HWIP_W]         = c.hw_ip;
    w[SWIP_LSB +: SWIP_W]         = c.sw_ip;
    w[CODE_LSB +: CODE_W]         = c.code;
    return w;
  endfunction
endpackage

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_capture_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic [CODE_W-1:0]   cap_code,
  input  logic                cap_in_delay,
  input  logic [COP_W-1:0]    cap_cop,
  input  logic [HWIP_W-1:0]   hw_pend,
  input  logic                sw_en,
  input  logic [SWIP_W-1:0]   sw_bits,
  output logic [CAUSE_W-1:0]  cause_o
);
  cause_t cur_q, cur_d;
  logic   reg_en;

  always_comb begin
    cur_d       = cur_q;
    cur_d.hw_ip = hw_pend;
    if (sw_en) begin
      cur_d.sw_ip = sw_bits;
    end
    if (cap_en) begin
      cur_d.bd   = cap_in_delay;
      cur_d.cop  = cap_cop;
      cur_d.code = cap_code;
    end
  end

  // hardware pending bits sample every cycle, so the enable is always on
  assign reg_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (reg_en) begin
      cur_q <= cur_d;
    end
  end

  assign cause_o = pack_cause(cur_q);
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter bit HAS_DELAY  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [XLEN-1:0] cap_pc,
  input  logic            cap_in_delay,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] addr_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] target;
  logic [XLEN-1:0] addr_q, addr_d;
  logic            addr_en;

  generate
    if (HAS_DELAY) begin : g_adjust
      assign target = cap_in_delay ? (cap_pc - STEP) : cap_pc;
    end else begin : g_plain
      logic unused_delay;
      assign unused_delay = cap_in_delay;
      assign target       = cap_pc;
    end
  endgenerate

  always_comb begin
    addr_en = cap_en | wr_en;
    addr_d  = addr_q;
    if (wr_en)  addr_d = wr_data;
    if (cap_en) addr_d = target;  // hardware capture has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/exc_capture_top.sv
module exc_capture_top
  import exc_capture_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_take,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [XLEN-1:0]     exc_pc,
  input  logic                exc_in_delay,
  input  logic [COP_W-1:0]    exc_cop_num,
  input  logic                err_take,
  input  logic [XLEN-1:0]     err_pc,
  input  logic [EXT_W-1:0]    ext_irq,
  input  logic                timer_irq,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [XLEN-1:0]     wr_data,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [XLEN-1:0]     epc_q,
  output logic [XLEN-1:0]     errorepc_q
);
  wr_sel_e sel;
  logic    wr_cause, wr_epc, wr_err;

  assign sel      = wr_sel_e'(wr_sel);
  assign wr_cause = wr_en && (sel == SEL_CAUSE);
  assign wr_epc   = wr_en && (sel == SEL_EPC);
  assign wr_err   = wr_en && (sel == SEL_ERR_EPC);

  exc_cause_reg u_cause (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (exc_take),
    .cap_code     (exc_code),
    .cap_in_delay (exc_in_delay),
    .cap_cop      (exc_cop_num),
    .hw_pend      ({timer_irq, ext_irq}),
    .sw_en        (wr_cause),
    .sw_bits      (wr_data[SWIP_W-1:0]),
    .cause_o      (cause_q)
  );

  exc_ret_addr #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .HAS_DELAY(1'b1)) u_epc (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (exc_take),
    .cap_pc       (exc_pc),
    .cap_in_delay (exc_in_delay),
    .wr_en        (wr_epc),
    .wr_data      (wr_data),
    .addr_o       (epc_q)
  );

  exc_ret_addr #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .HAS_DELAY(1'b0)) u_err_epc (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (err_take),
    .cap_pc       (err_pc),
    .cap_in_delay (1'b0),
    .wr_en        (wr_err),
    .wr_data      (wr_data),
    .addr_o       (errorepc_q)
  );
endmodule

// File: rtl/exc_capture_chk.sv
module exc_capture_chk #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_take,
  input logic [4:0]      exc_code,
  input logic [XLEN-1:0] exc_pc,
  input logic            exc_in_delay,
  input logic [1:0]      exc_cop_num,
  input logic            err_take,
  input logic [XLEN-1:0] err_pc,
  input logic [4:0]      ext_irq,
  input logic            timer_irq,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [XLEN-1:0] wr_data,
  input logic [31:0]     cause_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] errorepc_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  assert_plain_epc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && !exc_in_delay |=> (epc_q == $past(exc_pc)) && !cause_q[31]);

  assert_delay_epc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && exc_in_delay |=> (epc_q == $past(exc_pc) - STEP) && cause_q[31]);

  assert_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> cause_q[6:2] == $past(exc_code));

  assert_cop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> cause_q[29:28] == $past(exc_cop_num));

  assert_hw_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cause_q[15:10] == {$past(timer_irq), $past(ext_irq)});

  assert_sw_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == 2'd0) |=> cause_q[9:8] == $past(wr_data[1:0]));

  assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable({cause_q[31], cause_q[29:28], cause_q[6:2]}));

  assert_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    {cause_q[30], cause_q[27:16], cause_q[7], cause_q[1:0]} == '0);

  assert_err_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_take |=> errorepc_q == $past(err_pc));

  assert_epc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take && !(wr_en && wr_sel == 2'd1) |=> $stable(epc_q));

  assert_epc_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == 2'd1) && !exc_take |=> epc_q == $past(wr_data));

  assert_err_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == 2'd2) && !err_take |=> errorepc_q == $past(wr_data));

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_take && !(wr_en && wr_sel == 2'd2) |=> $stable(errorepc_q));
endmodule

bind exc_capture_top exc_capture_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_chk (.*);

// File: tb/exc_capture_top_test.sv
module exc_capture_top_test;
  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic            exc_take;
  logic [4:0]      exc_code;
  logic [XLEN-1:0] exc_pc;
  logic            exc_in_delay;
  logic [1:0]      exc_cop_num;
  logic            err_take;
  logic [XLEN-1:0] err_pc;
  logic [4:0]      ext_irq;
  logic            timer_irq;
  logic            wr_en;
  logic [1:0]      wr_sel;
  logic [XLEN-1:0] wr_data;
  logic [31:0]     cause_q;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] errorepc_q;

  int n_tests = 0;
  int n_fail  = 0;

  exc_capture_top #(.XLEN(XLEN), .INSN_BYTES(4)) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {code[71:67], pc[66:35], delay[34], cop[33:32], expected return address[31:0]}
  localparam logic [71:0] VECS [6] = '{
    {5'h04, 32'h8000_0100, 1'b0, 2'd0, 32'h8000_0100},
    {5'h0B, 32'h8000_0204, 1'b1, 2'd2, 32'h8000_0200},
    {5'h1F, 32'hFFFF_FFFC, 1'b0, 2'd3, 32'hFFFF_FFFC},
    {5'h00, 32'h0000_0000, 1'b1, 2'd1, 32'hFFFF_FFFC},
    {5'h08, 32'h0000_0004, 1'b1, 2'd0, 32'h0000_0000},
    {5'h0A, 32'h1234_5678, 1'b0, 2'd1, 32'h1234_5678}
  };

  function automatic logic [31:0] cause_word(input logic bd, input logic [1:0] cop,
                                             input logic [7:0] ip, input logic [4:0] code);
    return {bd, 1'b0, cop, 12'h000, ip, 1'b0, code, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_take = 1'b0; exc_code = '0; exc_pc = '0; exc_in_delay = 1'b0; exc_cop_num = '0;
    err_take = 1'b0; err_pc = '0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] epc_hold, cause_hold;
    idle_inputs();
    ext_irq = '0; timer_irq = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cause", cause_q, 32'h0);
    check("R1 epc", epc_q, 32'h0);
    check("R1 errorepc", errorepc_q, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: ordinary exceptions, plain and delay-slot
    for (int i = 0; i < 6; i++) begin
      exc_take = 1'b1;
      exc_code = VECS[i][71:67];
      exc_pc = VECS[i][66:35];
      exc_in_delay = VECS[i][34];
      exc_cop_num = VECS[i][33:32];
      @(negedge clk);
      idle_inputs();
      check(VECS[i][34] ? "R3 delay epc" : "R2 plain epc", epc_q, VECS[i][31:0]);
      check("R4 R5 cause capture", cause_q,
            cause_word(VECS[i][34], VECS[i][33:32], 8'h00, VECS[i][71:67]));
    end
    // last vector: code 0A, cop 1, bd 0

    // R6 pending bits follow timer and external lines
    ext_irq = 5'b10101; timer_irq = 1'b1;
    @(negedge clk);
    check("R6 hw pend", {26'h0, cause_q[15:10]}, {26'h0, 6'b110101});
    ext_irq = 5'b01010; timer_irq = 1'b0;
    @(negedge clk);
    check("R6 hw pend change", {26'h0, cause_q[15:10]}, {26'h0, 6'b001010});

    // R7 cause write touches only software bits
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    idle_inputs();
    check("R7 sw set", cause_q, cause_word(1'b0, 2'd1, 8'b0010_1011, 5'h0A));
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hFFFF_FFFE;
    @(negedge clk);
    idle_inputs();
    check("R7 sw partial", cause_q, cause_word(1'b0, 2'd1, 8'b0010_1010, 5'h0A));

    // R9 software writes to the return-address registers and the unused target
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'hA5A5_0010;
    @(negedge clk);
    idle_inputs();
    check("R9 epc write", epc_q, 32'hA5A5_0010);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h5A5A_0020;
    @(negedge clk);
    idle_inputs();
    check("R9 errorepc write", errorepc_q, 32'h5A5A_0020);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'h0000_0000;
    @(negedge clk);
    idle_inputs();
    check("R9 sel3 epc", epc_q, 32'hA5A5_0010);
    check("R9 sel3 errorepc", errorepc_q, 32'h5A5A_0020);
    check("R9 sel3 cause", cause_q, cause_word(1'b0, 2'd1, 8'b0010_1010, 5'h0A));

    // R8 error entry: no delay adjustment, cause and epc untouched
    err_take = 1'b1; err_pc = 32'hBFC0_0000; exc_in_delay = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R8 errorepc", errorepc_q, 32'hBFC0_0000);
    check("R8 epc kept", epc_q, 32'hA5A5_0010);
    check("R8 cause kept", cause_q, cause_word(1'b0, 2'd1, 8'b0010_1010, 5'h0A));

    // R10 collisions
    exc_take = 1'b1; exc_pc = 32'h0000_2000; exc_code = 5'h02;
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    idle_inputs();
    check("R10 exc beats epc write", epc_q, 32'h0000_2000);
    err_take = 1'b1; err_pc = 32'hBFC0_0380;
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    idle_inputs();
    check("R10 err beats errorepc write", errorepc_q, 32'hBFC0_0380);
    exc_take = 1'b1; exc_pc = 32'h0000_0100; exc_in_delay = 1'b1;
    exc_code = 5'h0C; exc_cop_num = 2'd1;
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_0001;
    @(negedge clk);
    idle_inputs();
    check("R10 cause merge", cause_q, cause_word(1'b1, 2'd1, 8'b0010_1001, 5'h0C));
    check("R10 R3 epc", epc_q, 32'h0000_00FC);

    // R2 clears the delay flag set just before
    epc_hold = epc_q;
    cause_hold = cause_q;
    exc_take = 1'b1; exc_pc = 32'h0000_0300; exc_code = 5'h05; exc_cop_num = 2'd1;
    @(negedge clk);
    idle_inputs();
    check("R2 bd cleared", {31'h0, cause_q[31]}, 32'h0);
    check("R2 epc", epc_q, 32'h0000_0300);
    check("R2 changed", {31'h0, epc_q != epc_hold}, {31'h0, cause_hold[31]});

    // R1 reset again from a busy state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 cause after reset", cause_q, 32'h0);
    check("R1 errorepc after reset", errorepc_q, 32'h0);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule